// File: doc/BRIEF.md
# Double-Buffered Split-Byte DAC Code Register

This block is the clocked digital front end of a 12-bit voltage-output converter. A parallel bus writes into two input registers: an 8-bit low register and a 4-bit high register. Each register has its own active-low select, and both share an active-low write strobe. A second rank, the DAC register, copies the joined input registers while an active-low load strobe is low. It holds its value once the load strobe returns high. The DAC register value is the straight-binary code that drives the converter: code 0 selects the bottom of the ladder and code 4095 selects one LSB below the top.

All strobes and the bus pass through the same synchronizer depth on the system clock, so a strobe level and the data that goes with it are seen in the same cycle. While a strobe is low, the register it enables follows the bus. When any enabling strobe rises, the register keeps the value it captured in the cycle before the edge. When write, both selects and load are all low, the bus reaches the output directly.

An active-low clear and the reset both zero every register at once. Clear wins over every load path. A build parameter picks the bus mode: wide 12-bit, or narrow 8-bit where the high nibble comes from bus bits 3:0 in a separate select cycle. A one-cycle pulse marks every change of the output code that a load causes.

Top module: `dac_dbuf_front`

## Requirements
- R1: With write and the low select both low, bus bits 7:0 load the low input register, which is bits 7:0 of the code.
- R2: In wide mode (BUS_MODE = 0), with write and the high select both low, bus bits 11:8 load the high input register, which is bits 11:8 of the code.
- R3: An input register keeps its value while write or its own select is high, so a write to one half leaves the other half unchanged.
- R4: While load is low, the code follows {high, low} of the input registers. While load is high, the code holds.
- R5: With write, both selects and load all low, the code equals the bus value.
- R6: Clear low zeros both input registers and the code at once and forces upd_o low, whatever the other inputs do. Loading resumes on the first clock edge after clear goes high.
- R7: After reset the code is 0 and upd_o is 0.
- R8: In narrow mode (BUS_MODE = 1), a high-select write takes the high nibble from bus bits 3:0.
- R9: upd_o is high for exactly the one cycle in which a new code value appears. It stays low while the code is unchanged, including when a load writes back the same value.
- R10: With SYNC_STAGES = 2, a change at the inputs reaches the code on the third rising clock edge after it is applied, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clr_ni | input | 1 | Active-low clear of all registers; asserts at once, release takes effect on the next clock edge |
| data_i | input | 12 | Parallel data bus |
| wr_ni | input | 1 | Active-low write strobe shared by both input halves |
| cs_lo_ni | input | 1 | Active-low select of the low 8-bit input register |
| cs_hi_ni | input | 1 | Active-low select of the high 4-bit input register |
| ld_ni | input | 1 | Active-low load strobe of the DAC register |
| code_o | output | 12 | DAC register code, straight binary |
| upd_o | output | 1 | One-cycle pulse when code_o takes a new value |

## Verification
The bench sweeps every code through the fully transparent path on a wide-mode instance and a narrow-mode instance at once. Each code is checked one cycle before it is due and again when it arrives, so a synchronizer or data pipe of the wrong depth shows up as early or late data, and a narrow instance that kept bus bits 11:8 shows the wrong nibble. Split writes with load held high then check that each half holds on its own and that the code holds. A design that latched both halves on any select, or let the second rank run through, would show the new value too early. Clear is checked with all strobes low and a nonzero bus, which catches a load path that wins over clear or keeps running during it. The update pulse is checked on a load that writes back the value already held, where a pulse tied to the load strobe rather than to a change of value would fire.

// File: rtl/dac_front_pkg.sv
package dac_front_pkg;
  typedef enum logic {
    BUS_WIDE   = 1'b0,
    BUS_NARROW = 1'b1
  } bus_mode_e;

  localparam int unsigned CODE_W_DEF = 12;
  localparam int unsigned LO_W_DEF   = 8;
endpackage

// File: rtl/dac_sync_pipe.sv
module dac_sync_pipe #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_BIT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= {WIDTH{RST_BIT}};
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dac_input_rank.sv
module dac_input_rank
  import dac_front_pkg::*;
#(
  parameter int unsigned CODE_W   = 12,
  parameter int unsigned LO_W     = 8,
  parameter bus_mode_e   BUS_MODE = BUS_WIDE,
  localparam int unsigned HI_W    = CODE_W - LO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arst_ni,
  input  logic [CODE_W-1:0] data_i,
  input  logic              wr_n_i,
  input  logic              cs_lo_n_i,
  input  logic              cs_hi_n_i,
  output logic [CODE_W-1:0] code_nxt_o
);
  logic [LO_W-1:0] lo_q, lo_d;
  logic [HI_W-1:0] hi_q, hi_d, hi_src;
  logic            live_q;

  if (BUS_MODE == BUS_NARROW) begin : g_narrow
    assign hi_src = data_i[HI_W-1:0];
  end else begin : g_wide
    assign hi_src = data_i[CODE_W-1:LO_W];
  end

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (!wr_n_i && !cs_lo_n_i) lo_d = data_i[LO_W-1:0];
    if (!wr_n_i && !cs_hi_n_i) hi_d = hi_src;
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      lo_q   <= '0;
      hi_q   <= '0;
      live_q <= 1'b0;
    end else begin
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      live_q <= 1'b1;
    end
  end

  // the second rank sees this cycle's value so that all-low is transparent
  assign code_nxt_o = {hi_d, lo_d};

  // R3
  lo_hold_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    live_q && (wr_n_i || cs_lo_n_i) |=> $stable(lo_q));
  // R3
  hi_hold_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    live_q && (wr_n_i || cs_hi_n_i) |=> $stable(hi_q));
  // R6
  in_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arst_ni |-> (lo_q == '0 && hi_q == '0));
endmodule

// File: rtl/dac_output_rank.sv
module dac_output_rank #(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arst_ni,
  input  logic [CODE_W-1:0] code_in_i,
  input  logic              ld_n_i,
  output logic [CODE_W-1:0] code_o,
  output logic              upd_o
);
  logic [CODE_W-1:0] code_q, code_d;
  logic              upd_q, live_q;

  assign code_d = ld_n_i ? code_q : code_in_i;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      code_q <= '0;
      upd_q  <= 1'b0;
      live_q <= 1'b0;
    end else begin
      code_q <= code_d;
      upd_q  <= (code_d != code_q);
      live_q <= 1'b1;
    end
  end

  assign code_o = code_q;
  assign upd_o  = upd_q;

  // R4
  dac_hold_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    live_q && ld_n_i |=> $stable(code_q));
  // R9
  upd_change_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    live_q && upd_q |-> (code_q != $past(code_q)));
  // R9
  change_upd_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    live_q && (code_q != $past(code_q)) |-> upd_q);
  // R6
  out_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arst_ni |-> (code_q == '0 && !upd_q));
endmodule

// File: rtl/dac_dbuf_front.sv
module dac_dbuf_front
  import dac_front_pkg::*;
#(
  parameter int unsigned CODE_W      = CODE_W_DEF,
  parameter int unsigned LO_W        = LO_W_DEF,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bus_mode_e   BUS_MODE    = BUS_WIDE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_ni,
  input  logic [CODE_W-1:0] data_i,
  input  logic              wr_ni,
  input  logic              cs_lo_ni,
  input  logic              cs_hi_ni,
  input  logic              ld_ni,
  output logic [CODE_W-1:0] code_o,
  output logic              upd_o
);
  localparam int unsigned N_STB = 4;

  logic [N_STB-1:0]  stb_s;
  logic [CODE_W-1:0] data_s, code_nxt;
  logic              arst_n;

  assign arst_n = rst_ni & clr_ni;

  dac_sync_pipe #(.WIDTH(N_STB), .STAGES(SYNC_STAGES), .RST_BIT(1'b1)) i_stb_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ld_ni, cs_hi_ni, cs_lo_ni, wr_ni}),
    .q_o   (stb_s)
  );

  // bus delayed by the same depth so strobe and data stay aligned
  dac_sync_pipe #(.WIDTH(CODE_W), .STAGES(SYNC_STAGES), .RST_BIT(1'b0)) i_data_pipe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (data_i),
    .q_o   (data_s)
  );

  dac_input_rank #(.CODE_W(CODE_W), .LO_W(LO_W), .BUS_MODE(BUS_MODE)) i_in_rank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arst_ni   (arst_n),
    .data_i    (data_s),
    .wr_n_i    (stb_s[0]),
    .cs_lo_n_i (stb_s[1]),
    .cs_hi_n_i (stb_s[2]),
    .code_nxt_o(code_nxt)
  );

  dac_output_rank #(.CODE_W(CODE_W)) i_out_rank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arst_ni  (arst_n),
    .code_in_i(code_nxt),
    .ld_n_i   (stb_s[3]),
    .code_o   (code_o),
    .upd_o    (upd_o)
  );
endmodule

// File: tb/test_dac_dbuf_front.sv
`timescale 1ns/1ps
module test_dac_dbuf_front;
  import dac_front_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, clr_n = 1'b1;
  logic [11:0] bus = '0;
  logic        wr_n = 1'b0, cs_lo_n = 1'b0, cs_hi_n = 1'b0, ld_n = 1'b0;
  logic [11:0] code_w, code_m;
  logic        upd_w, upd_m;
  int          checks = 0, errors = 0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  dac_dbuf_front #(.BUS_MODE(BUS_WIDE)) i_dac_dbuf_front (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n), .data_i(bus),
    .wr_ni(wr_n), .cs_lo_ni(cs_lo_n), .cs_hi_ni(cs_hi_n), .ld_ni(ld_n),
    .code_o(code_w), .upd_o(upd_w)
  );

  dac_dbuf_front #(.BUS_MODE(BUS_NARROW)) i_dac_dbuf_front_nar (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n), .data_i(bus),
    .wr_ni(wr_n), .cs_lo_ni(cs_lo_n), .cs_hi_ni(cs_hi_n), .ld_ni(ld_n),
    .code_o(code_m), .upd_o(upd_m)
  );

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] w_lo, m_lo;
    cyc(2);
    // R7 reset state
    chk("R7 code", code_w, 12'h000);
    chk("R7 upd", {11'b0, upd_w}, 12'h000);
    rst_n = 1'b1;
    cyc(4);
    chk("R7 code after start", code_w, 12'h000);

    // R5 R10 R8 R9: all strobes low, sweep every code
    for (int v = 1; v < 4096; v++) begin
      bus = 12'(v);
      cyc(2);
      chk("R10 not before third edge", code_w, 12'(v - 1));
      cyc(1);
      chk("R5 transparent", code_w, 12'(v));
      chk("R8 narrow transparent", code_m, {bus[3:0], bus[7:0]});
      chk("R9 upd on change", {11'b0, upd_w}, 12'h001);
    end
    cyc(1);
    chk("R9 single cycle pulse", {11'b0, upd_w}, 12'h000);

    // R9 same value reload: no pulse
    cyc(3);
    for (int k = 0; k < 4; k++) begin
      chk("R9 no pulse when unchanged", {11'b0, upd_w}, 12'h000);
      cyc(1);
    end

    // split writes with load held high
    wr_n = 1'b1; cs_lo_n = 1'b1; cs_hi_n = 1'b1; ld_n = 1'b1;
    cyc(4);
    bus = 12'h5A3;
    cs_lo_n = 1'b0; wr_n = 1'b0;
    cyc(2);
    wr_n = 1'b1; cs_lo_n = 1'b1;
    bus = 12'h0C6;
    cyc(4);
    chk("R4 hold while load high", code_w, 12'hFFF);
    // R3 write low but no select: nothing changes
    wr_n = 1'b0;
    cyc(4);
    wr_n = 1'b1;
    cyc(1);
    ld_n = 1'b0;
    cyc(4);
    ld_n = 1'b1;
    cyc(3);
    chk("R1 low byte load", code_w, 12'hFA3);
    chk("R3 high half kept", code_m, 12'hFA3);
    w_lo = 8'hA3; m_lo = 8'hA3;

    // R2 / R8 high write only
    bus = 12'h7D9;
    cs_hi_n = 1'b0; wr_n = 1'b0;
    cyc(2);
    wr_n = 1'b1; cs_hi_n = 1'b1;
    bus = 12'h000;
    cyc(4);
    chk("R4 hold before load", code_w, 12'hFA3);
    ld_n = 1'b0;
    cyc(4);
    chk("R2 high nibble from 11:8", code_w, {4'h7, w_lo[7:0]});
    chk("R8 narrow high nibble from 3:0", code_m, {4'h9, m_lo[7:0]});
    chk("R3 low half kept", {4'h0, code_w[7:0]}, 12'h0A3);
    // R4 load low follows later input writes
    bus = 12'h21E;
    cs_lo_n = 1'b0; cs_hi_n = 1'b0; wr_n = 1'b0;
    cyc(2);
    wr_n = 1'b1; cs_lo_n = 1'b1; cs_hi_n = 1'b1;
    cyc(4);
    chk("R4 follows while load low", code_w, 12'h21E);
    chk("R8 narrow both halves", code_m, 12'hE1E);

    // R6 clear with all strobes low and bus nonzero
    bus = 12'hB6C;
    wr_n = 1'b0; cs_lo_n = 1'b0; cs_hi_n = 1'b0; ld_n = 1'b0;
    cyc(4);
    chk("R5 before clear", code_w, 12'hB6C);
    clr_n = 1'b0;
    #1;
    chk("R6 immediate zero", code_w, 12'h000);
    chk("R6 upd forced low", {11'b0, upd_w}, 12'h000);
    cyc(4);
    chk("R6 priority over loads", code_w, 12'h000);
    chk("R6 narrow priority", code_m, 12'h000);
    clr_n = 1'b1;
    cyc(1);
    chk("R6 resumes next edge", code_w, 12'hB6C);

    // R6 clear zeros input registers too
    wr_n = 1'b1; cs_lo_n = 1'b1; cs_hi_n = 1'b1; ld_n = 1'b1;
    cyc(4);
    clr_n = 1'b0;
    cyc(2);
    clr_n = 1'b1;
    cyc(1);
    ld_n = 1'b0;
    cyc(4);
    chk("R6 input registers cleared", code_w, 12'h000);
    chk("R9 no pulse at zero reload", {11'b0, upd_w}, 12'h000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule